// File: doc/BRIEF.md
# Dual-Cluster Register File with Bundle Conflict Checker

This block is the register storage for a datapath built from two clusters of functional units. Each cluster owns one file of sixteen 32-bit registers: cluster 0 owns file A and cluster 1 owns file B. Every cycle the block receives one bundle, which holds all the read requests, write requests and memory-pointer declarations of both clusters. The checker tests the bundle against a set of structural port rules. A legal bundle commits its writes. An illegal bundle commits no writes and raises an error flag, together with a code that names the first rule it broke.

Each read port belongs to one cluster and reads that cluster's own file. A read port may instead take the single crossing path to the other file. Write ports write only their own cluster's file. A 40-bit access works on an even/odd register pair: the even register holds bits 31:0 and the odd register holds bits 39:32. Read data and the error result are registered. Reads always return the contents held before the same bundle's writes take effect.

Top module: `dual_cluster_regfile`

## Requirements
- R1: After reset all registers hold zero. `bundleErr` is 0, `errCode` is 0 and every `rdData` lane is 0.
- R2: Read port p belongs to cluster p / RD_PER_CL, and write port w belongs to cluster w / WR_PER_CL. Cluster 0 uses file A and cluster 1 uses file B. One cycle after a narrow read, its lane shows {8'h00, register}, using the value held before that bundle's writes. A disabled read port's lane shows 0. A committed narrow write stores wrData[31:0].
- R3: A read with `rdCross` set reads the other cluster's file. If two or more reads from the same cluster set `rdCross` in one bundle, the error code is 2.
- R4: A committed 40-bit write to even base e stores data[31:0] in register e and {24'h0, data[39:32]} in register e+1. A 40-bit read of base e returns {reg(e+1)[7:0], reg(e)}. A 40-bit read or write whose base index is odd gives error code 1.
- R5: If any single register is read more than MAX_FANOUT (4) times in one bundle, the error code is 3. A 40-bit read counts as one read of each register in its pair.
- R6: If more than one 40-bit write appears in a bundle, the error code is 4.
- R7: If a bundle holds both a 40-bit read and a 40-bit write, the error code is 5.
- R8: If the same register of one file is written twice in a bundle, the error code is 6. A 40-bit write counts as writing both registers of its pair. Equal indices in different files do not clash.
- R9: If both `memEn` bits are set and both `memPtrFile` bits are equal, the error code is 7. In `memPtrFile`, 0 means file A and 1 means file B.
- R10: When a bundle breaks any rule, none of its writes is performed. One cycle later `bundleErr` is 1 and `errCode` holds the lowest-numbered code among the broken rules. Reads are still returned. When a bundle breaks no rule, `bundleErr` and `errCode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | NRD | Read port enables |
| rdCross | input | NRD | Read from the opposite cluster's file |
| rdWide | input | NRD | 40-bit pair read |
| rdIdx | input | NRD*4 | Register index per read port |
| wrEn | input | NWR | Write port enables |
| wrWide | input | NWR | 40-bit pair write |
| wrIdx | input | NWR*4 | Register index per write port |
| wrData | input | NWR*40 | Write data per port |
| memEn | input | 2 | Memory access present, one bit per cluster |
| memPtrFile | input | 2 | File holding each access's address pointer (0 = A, 1 = B) |
| rdData | output | NRD*40 | Registered read data per port |
| bundleErr | output | 1 | Registered: previous bundle broke a rule |
| errCode | output | 3 | Registered: first rule broken, 0 when legal |

## Verification
Every result of this block is due exactly one rising edge after its bundle is applied. This covers the read lanes, the error flag and code, and the effect of the writes on later reads. The bench drives each bundle on a falling edge and compares all outputs on the next falling edge, which is after the capturing rising edge. It then reads back registers in later bundles, which confirms that suppressed writes never landed. Expected values come from a bench-side model of both files and a separate rule evaluator that applies the code priority.

// File: rtl/rfcl_pkg.sv
package rfcl_pkg;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_ODD_BASE = 3'd1,
    ERR_CROSS    = 3'd2,
    ERR_FANOUT   = 3'd3,
    ERR_WIDE_WR  = 3'd4,
    ERR_WIDE_RW  = 3'd5,
    ERR_WR_CLASH = 3'd6,
    ERR_MEM_PTR  = 3'd7
  } errCode_e;

  typedef struct packed {
    logic commit;    // bundle legal: perform its writes
    logic anyWide;   // bundle carries a 40-bit write
  } ctrlStrobe_t;

endpackage

// File: rtl/rfcl_conflict_ctrl.sv
module rfcl_conflict_ctrl
  import rfcl_pkg::*;
#(
  parameter int RD_PER_CL  = 4,
  parameter int WR_PER_CL  = 2,
  parameter int NUM_REGS   = 16,
  parameter int MAX_FANOUT = 4,
  localparam int IDX_W = $clog2(NUM_REGS),
  localparam int NRD   = 2 * RD_PER_CL,
  localparam int NWR   = 2 * WR_PER_CL
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NRD-1:0]       rdEn,
  input  logic [NRD-1:0]       rdCross,
  input  logic [NRD-1:0]       rdWide,
  input  logic [NRD*IDX_W-1:0] rdIdx,
  input  logic [NWR-1:0]       wrEn,
  input  logic [NWR-1:0]       wrWide,
  input  logic [NWR*IDX_W-1:0] wrIdx,
  input  logic [1:0]           memEn,
  input  logic [1:0]           memPtrFile,
  output ctrlStrobe_t          strobe,
  output logic                 bundleErr,
  output errCode_e             errCode
);

  int rdHits [2][NUM_REGS];
  int wrHits [2][NUM_REGS];
  int crossN [2];
  int wideWrN;
  logic oddBase, wideRd, fanViol, clash, crossViol, memViol;
  logic rFile, wFile;
  logic [IDX_W-1:0] rIdx, wIdx;
  errCode_e code;

  // Tally reads and writes per physical register
  always_comb begin
    oddBase = 1'b0;
    wideRd  = 1'b0;
    wideWrN = 0;
    crossN[0] = 0;
    crossN[1] = 0;
    rFile = 1'b0;
    wFile = 1'b0;
    rIdx  = '0;
    wIdx  = '0;
    for (int f = 0; f < 2; f++) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        rdHits[f][r] = 0;
        wrHits[f][r] = 0;
      end
    end
    for (int p = 0; p < NRD; p++) begin
      if (rdEn[p]) begin
        rFile = ((p / RD_PER_CL) != 0) ^ rdCross[p];
        rIdx  = rdIdx[p*IDX_W +: IDX_W];
        if (rdCross[p]) crossN[p / RD_PER_CL] += 1;
        if (rdWide[p]) begin
          wideRd = 1'b1;
          if (rIdx[0]) oddBase = 1'b1;
          rdHits[rFile][{rIdx[IDX_W-1:1], 1'b0}] += 1;
          rdHits[rFile][{rIdx[IDX_W-1:1], 1'b1}] += 1;
        end else begin
          rdHits[rFile][rIdx] += 1;
        end
      end
    end
    for (int w = 0; w < NWR; w++) begin
      if (wrEn[w]) begin
        wFile = ((w / WR_PER_CL) != 0);
        wIdx  = wrIdx[w*IDX_W +: IDX_W];
        if (wrWide[w]) begin
          wideWrN += 1;
          if (wIdx[0]) oddBase = 1'b1;
          wrHits[wFile][{wIdx[IDX_W-1:1], 1'b0}] += 1;
          wrHits[wFile][{wIdx[IDX_W-1:1], 1'b1}] += 1;
        end else begin
          wrHits[wFile][wIdx] += 1;
        end
      end
    end
  end

  // Scan the tallies
  always_comb begin
    fanViol = 1'b0;
    clash   = 1'b0;
    for (int f = 0; f < 2; f++) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (rdHits[f][r] > MAX_FANOUT) fanViol = 1'b1;
        if (wrHits[f][r] > 1) clash = 1'b1;
      end
    end
    crossViol = (crossN[0] > 1) || (crossN[1] > 1);
    memViol   = (&memEn) && (memPtrFile[0] == memPtrFile[1]);
  end

  // Fixed priority: lowest code wins
  always_comb begin
    if (oddBase)                      code = ERR_ODD_BASE;
    else if (crossViol)               code = ERR_CROSS;
    else if (fanViol)                 code = ERR_FANOUT;
    else if (wideWrN > 1)             code = ERR_WIDE_WR;
    else if (wideRd && wideWrN > 0)   code = ERR_WIDE_RW;
    else if (clash)                   code = ERR_WR_CLASH;
    else if (memViol)                 code = ERR_MEM_PTR;
    else                              code = ERR_NONE;
    strobe.commit  = (code == ERR_NONE);
    strobe.anyWide = (wideWrN > 0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bundleErr <= 1'b0;
      errCode   <= ERR_NONE;
    end else begin
      bundleErr <= (code != ERR_NONE);
      errCode   <= code;
    end
  end

  // R4: odd-base wide read on port 0 is always reported with the top code
  assert_odd_base_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn[0] && rdWide[0] && rdIdx[0]) |=> (bundleErr && errCode == ERR_ODD_BASE));

  // R9: same pointer file for both memory accesses
  assert_mem_ptr_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((&memEn) && memPtrFile[0] == memPtrFile[1]) |=> bundleErr);

  // R6: two or more wide writes
  assert_wide_wr_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(wrEn & wrWide) > 1) |=> bundleErr);

  // R10: an empty bundle is legal
  assert_idle_legal_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn == '0 && wrEn == '0 && memEn != 2'b11) |=> (!bundleErr && errCode == ERR_NONE));

endmodule

// File: rtl/rfcl_datapath.sv
module rfcl_datapath
  import rfcl_pkg::*;
#(
  parameter int RD_PER_CL = 4,
  parameter int WR_PER_CL = 2,
  parameter int NUM_REGS  = 16,
  parameter int DATA_W    = 32,
  parameter int EXT_W     = 8,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int WIDE_W = DATA_W + EXT_W,
  localparam int NRD    = 2 * RD_PER_CL,
  localparam int NWR    = 2 * WR_PER_CL
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [NRD-1:0]        rdEn,
  input  logic [NRD-1:0]        rdCross,
  input  logic [NRD-1:0]        rdWide,
  input  logic [NRD*IDX_W-1:0]  rdIdx,
  input  logic [NWR-1:0]        wrEn,
  input  logic [NWR-1:0]        wrWide,
  input  logic [NWR*IDX_W-1:0]  wrIdx,
  input  logic [NWR*WIDE_W-1:0] wrData,
  output logic [NRD*WIDE_W-1:0] rdData
);

  logic [DATA_W-1:0] regFile [2][NUM_REGS];

  // Writes land only when the checker commits the bundle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int f = 0; f < 2; f++)
        for (int r = 0; r < NUM_REGS; r++)
          regFile[f][r] <= '0;
    end else if (strobe.commit) begin
      for (int w = 0; w < NWR; w++) begin
        if (wrEn[w]) begin
          if (wrWide[w]) begin
            regFile[w / WR_PER_CL][{wrIdx[w*IDX_W+1 +: IDX_W-1], 1'b0}] <=
              wrData[w*WIDE_W +: DATA_W];
            regFile[w / WR_PER_CL][{wrIdx[w*IDX_W+1 +: IDX_W-1], 1'b1}] <=
              {{(DATA_W-EXT_W){1'b0}}, wrData[w*WIDE_W+DATA_W +: EXT_W]};
          end else begin
            regFile[w / WR_PER_CL][wrIdx[w*IDX_W +: IDX_W]] <=
              wrData[w*WIDE_W +: DATA_W];
          end
        end
      end
    end
  end

  // Read lanes: registered, sampling the pre-write contents
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    localparam int CL = p / RD_PER_CL;
    logic              fileSel;
    logic [IDX_W-1:0]  idx, evenIdx, oddIdx;
    logic [WIDE_W-1:0] rdNext;

    assign fileSel = (CL != 0) ^ rdCross[p];
    assign idx     = rdIdx[p*IDX_W +: IDX_W];
    assign evenIdx = {idx[IDX_W-1:1], 1'b0};
    assign oddIdx  = {idx[IDX_W-1:1], 1'b1};

    always_comb begin
      if (!rdEn[p])
        rdNext = '0;
      else if (rdWide[p])
        rdNext = {regFile[fileSel][oddIdx][EXT_W-1:0], regFile[fileSel][evenIdx]};
      else
        rdNext = {{EXT_W{1'b0}}, regFile[fileSel][idx]};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rdData[p*WIDE_W +: WIDE_W] <= '0;
      else       rdData[p*WIDE_W +: WIDE_W] <= rdNext;
    end
  end

  // R2: committed narrow write on port 0 lands in file A
  assert_narrow_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && wrEn[0] && !wrWide[0]) |=>
      (regFile[0][$past(wrIdx[IDX_W-1:0])] == $past(wrData[DATA_W-1:0])));

  // R10: a rejected bundle leaves the target of port 0 untouched
  assert_blocked_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.commit && wrEn[0] && !wrWide[0]) |=>
      (regFile[0][$past(wrIdx[IDX_W-1:0])] == $past(regFile[0][wrIdx[IDX_W-1:0]])));

endmodule

// File: rtl/dual_cluster_regfile.sv
module dual_cluster_regfile
  import rfcl_pkg::*;
#(
  parameter int RD_PER_CL  = 4,
  parameter int WR_PER_CL  = 2,
  parameter int NUM_REGS   = 16,
  parameter int DATA_W     = 32,
  parameter int EXT_W      = 8,
  parameter int MAX_FANOUT = 4,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int WIDE_W = DATA_W + EXT_W,
  localparam int NRD    = 2 * RD_PER_CL,
  localparam int NWR    = 2 * WR_PER_CL
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NRD-1:0]        rdEn,
  input  logic [NRD-1:0]        rdCross,
  input  logic [NRD-1:0]        rdWide,
  input  logic [NRD*IDX_W-1:0]  rdIdx,
  input  logic [NWR-1:0]        wrEn,
  input  logic [NWR-1:0]        wrWide,
  input  logic [NWR*IDX_W-1:0]  wrIdx,
  input  logic [NWR*WIDE_W-1:0] wrData,
  input  logic [1:0]            memEn,
  input  logic [1:0]            memPtrFile,
  output logic [NRD*WIDE_W-1:0] rdData,
  output logic                  bundleErr,
  output logic [2:0]            errCode
);

  ctrlStrobe_t strobe;
  errCode_e    codeQ;

  rfcl_conflict_ctrl #(
    .RD_PER_CL(RD_PER_CL), .WR_PER_CL(WR_PER_CL),
    .NUM_REGS(NUM_REGS), .MAX_FANOUT(MAX_FANOUT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .rdEn(rdEn), .rdCross(rdCross), .rdWide(rdWide), .rdIdx(rdIdx),
    .wrEn(wrEn), .wrWide(wrWide), .wrIdx(wrIdx),
    .memEn(memEn), .memPtrFile(memPtrFile),
    .strobe(strobe), .bundleErr(bundleErr), .errCode(codeQ)
  );

  rfcl_datapath #(
    .RD_PER_CL(RD_PER_CL), .WR_PER_CL(WR_PER_CL),
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .EXT_W(EXT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdEn(rdEn), .rdCross(rdCross), .rdWide(rdWide), .rdIdx(rdIdx),
    .wrEn(wrEn), .wrWide(wrWide), .wrIdx(wrIdx), .wrData(wrData),
    .rdData(rdData)
  );

  assign errCode = codeQ;

endmodule

// File: tb/test_dual_cluster_regfile.sv
`timescale 1ns/1ps
module test_dual_cluster_regfile;

  localparam int RPC = 4, WPC = 2, NRD = 8, NWR = 4, NREG = 16;
  localparam real CLK_PER = 20.0;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NRD-1:0]    rdEn, rdCross, rdWide;
  logic [NRD*4-1:0]  rdIdx;
  logic [NWR-1:0]    wrEn, wrWide;
  logic [NWR*4-1:0]  wrIdx;
  logic [NWR*40-1:0] wrData;
  logic [1:0]        memEn, memPtrFile;
  logic [NRD*40-1:0] rdData;
  logic              bundleErr;
  logic [2:0]        errCode;

  int checks = 0, errors = 0;
  logic [31:0] mReg [2][NREG];

  always #(CLK_PER/2) clk = ~clk;

  dual_cluster_regfile i_dual_cluster_regfile (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdCross(rdCross), .rdWide(rdWide),
    .rdIdx(rdIdx), .wrEn(wrEn), .wrWide(wrWide), .wrIdx(wrIdx), .wrData(wrData),
    .memEn(memEn), .memPtrFile(memPtrFile), .rdData(rdData),
    .bundleErr(bundleErr), .errCode(errCode)
  );

  task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    rdEn = '0; rdCross = '0; rdWide = '0; rdIdx = '0;
    wrEn = '0; wrWide = '0; wrIdx = '0; wrData = '0;
    memEn = '0; memPtrFile = '0;
  endtask

  task automatic setRd(int p, bit x, bit w, int idx);
    rdEn[p] = 1'b1; rdCross[p] = x; rdWide[p] = w; rdIdx[p*4 +: 4] = 4'(idx);
  endtask

  task automatic setWr(int w, bit wide, int idx, logic [39:0] d);
    wrEn[w] = 1'b1; wrWide[w] = wide; wrIdx[w*4 +: 4] = 4'(idx); wrData[w*40 +: 40] = d;
  endtask

  // Rule evaluator built from R3..R9 with R10 priority
  function automatic logic [2:0] refCode();
    int rh [2][NREG];
    int wh [2][NREG];
    int cx [2];
    int nWw = 0;
    bit odd = 0, wRd = 0, fan = 0, cl = 0, mem;
    cx[0] = 0; cx[1] = 0;
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < NREG; r++) begin rh[f][r] = 0; wh[f][r] = 0; end
    for (int p = 0; p < NRD; p++) if (rdEn[p]) begin
      int f = (p / RPC) ^ int'(rdCross[p]);
      int i = int'(rdIdx[p*4 +: 4]);
      if (rdCross[p]) cx[p / RPC]++;
      if (rdWide[p]) begin
        wRd = 1; if (i % 2 == 1) odd = 1;
        rh[f][i & ~1]++; rh[f][i | 1]++;
      end else rh[f][i]++;
    end
    for (int w = 0; w < NWR; w++) if (wrEn[w]) begin
      int f = w / WPC;
      int i = int'(wrIdx[w*4 +: 4]);
      if (wrWide[w]) begin
        nWw++; if (i % 2 == 1) odd = 1;
        wh[f][i & ~1]++; wh[f][i | 1]++;
      end else wh[f][i]++;
    end
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < NREG; r++) begin
        if (rh[f][r] > 4) fan = 1;
        if (wh[f][r] > 1) cl = 1;
      end
    mem = (memEn == 2'b11) && (memPtrFile[0] == memPtrFile[1]);
    if (odd) return 3'd1;
    if (cx[0] > 1 || cx[1] > 1) return 3'd2;
    if (fan) return 3'd3;
    if (nWw > 1) return 3'd4;
    if (wRd && nWw > 0) return 3'd5;
    if (cl) return 3'd6;
    if (mem) return 3'd7;
    return 3'd0;
  endfunction

  function automatic logic [39:0] rdExp(int p);
    int f = (p / RPC) ^ int'(rdCross[p]);
    int i = int'(rdIdx[p*4 +: 4]);
    if (!rdEn[p]) return '0;
    if (rdWide[p]) return {mReg[f][i | 1][7:0], mReg[f][i & ~1]};
    return {8'h00, mReg[f][i]};
  endfunction

  // Apply current inputs for one cycle and check results one edge later
  task automatic runBundle(string tag, logic [2:0] expCode);
    logic [39:0] expRd [NRD];
    logic [2:0]  code = refCode();
    if (expCode !== code) begin
      checks++; errors++;
      $display("FAIL %s: bench rule table %0d expected %0d", tag, code, expCode);
    end
    for (int p = 0; p < NRD; p++) expRd[p] = rdExp(p);
    if (code == 3'd0) begin
      for (int w = 0; w < NWR; w++) if (wrEn[w]) begin
        int f = w / WPC;
        int i = int'(wrIdx[w*4 +: 4]);
        if (wrWide[w]) begin
          mReg[f][i & ~1] = wrData[w*40 +: 32];
          mReg[f][i | 1]  = {24'h0, wrData[w*40+32 +: 8]};
        end else mReg[f][i] = wrData[w*40 +: 32];
      end
    end
    @(negedge clk);
    chk({tag, " errCode R10"}, 40'(errCode), 40'(code));
    chk({tag, " bundleErr R10"}, 40'(bundleErr), 40'(code != 0));
    for (int p = 0; p < NRD; p++)
      chk($sformatf("%s rdData[%0d] R2", tag, p), rdData[p*40 +: 40], expRd[p]);
  endtask

  initial begin
    #(CLK_PER * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int f = 0; f < 2; f++) for (int r = 0; r < NREG; r++) mReg[f][r] = '0;
    clearIn();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 bundleErr", 40'(bundleErr), 40'd0);
    chk("R1 errCode", 40'(errCode), 40'd0);
    chk("R1 rdData lane0", rdData[39:0], 40'd0);
    rstN = 1'b1;
    @(negedge clk);
    clearIn(); setRd(0, 0, 0, 9); setRd(5, 0, 0, 9);
    runBundle("R1 regs zero", 3'd0);

    // R2: narrow writes to A3 and B5
    clearIn(); setWr(0, 0, 3, 40'h11111111); setWr(2, 0, 5, 40'h22222222);
    runBundle("R2 write", 3'd0);
    // R2: read sees old value while same register is rewritten
    clearIn(); setRd(0, 0, 0, 3); setWr(0, 0, 3, 40'h33333333);
    runBundle("R2 read-before-write", 3'd0);
    clearIn(); setRd(1, 0, 0, 3); setRd(4, 0, 0, 5);
    runBundle("R2 readback", 3'd0);

    // R3: one cross read each way is legal
    clearIn(); setRd(0, 1, 0, 5); setRd(4, 1, 0, 3);
    runBundle("R3 cross legal", 3'd0);
    // R3: two cross reads from cluster 0, with a write that must be dropped (R10)
    clearIn(); setRd(0, 1, 0, 5); setRd(1, 1, 0, 5); setWr(0, 0, 3, 40'hDEAD);
    runBundle("R3 double cross", 3'd2);
    clearIn(); setRd(0, 0, 0, 3);
    runBundle("R10 write suppressed", 3'd0);

    // R4: wide pair write then wide and narrow reads
    clearIn(); setWr(0, 1, 6, 40'hAB_CAFEBABE);
    runBundle("R4 wide write", 3'd0);
    clearIn(); setRd(1, 0, 1, 6); setRd(2, 0, 0, 7); setRd(3, 0, 0, 6);
    runBundle("R4 wide read", 3'd0);
    clearIn(); setRd(1, 0, 1, 7);
    runBundle("R4 odd base read", 3'd1);
    clearIn(); setWr(3, 1, 9, 40'h1);
    runBundle("R4 odd base write", 3'd1);

    // R5: fan-out limit
    clearIn(); for (int p = 0; p < 4; p++) setRd(p, 0, 0, 3);
    runBundle("R5 four reads", 3'd0);
    clearIn(); for (int p = 0; p < 4; p++) setRd(p, 0, 0, 3); setRd(4, 1, 0, 3);
    runBundle("R5 five reads", 3'd3);
    clearIn(); for (int p = 0; p < 4; p++) setRd(p, 0, 0, 7); setRd(4, 1, 1, 6);
    runBundle("R5 wide counts pair", 3'd3);

    // R6: two wide writes
    clearIn(); setWr(0, 1, 0, 40'h5555); setWr(2, 1, 2, 40'h6666);
    runBundle("R6 two wide writes", 3'd4);
    // R7: wide read with wide write
    clearIn(); setRd(0, 0, 1, 6); setWr(2, 1, 4, 40'h7777);
    runBundle("R7 wide read+write", 3'd5);
    // R8: overlap of narrow and wide write in file A
    clearIn(); setWr(0, 0, 9, 40'h9); setWr(1, 1, 8, 40'h8);
    runBundle("R8 clash", 3'd6);
    clearIn(); setWr(0, 0, 9, 40'h99); setWr(2, 0, 9, 40'hBB);
    runBundle("R8 same idx other file", 3'd0);
    // R9: memory pointers
    clearIn(); memEn = 2'b11; memPtrFile = 2'b11;
    runBundle("R9 same file", 3'd7);
    clearIn(); memEn = 2'b11; memPtrFile = 2'b10;
    runBundle("R9 split files", 3'd0);
    // R10: priority, odd base beats memory rule
    clearIn(); memEn = 2'b11; setWr(0, 1, 3, 40'h1);
    runBundle("R10 priority", 3'd1);

    // Random bundles
    for (int n = 0; n < 400; n++) begin
      clearIn();
      for (int p = 0; p < NRD; p++)
        if ($urandom_range(1, 0) == 1)
          setRd(p, $urandom_range(7, 0) == 0, $urandom_range(5, 0) == 0, $urandom_range(15, 0));
      for (int w = 0; w < NWR; w++)
        if ($urandom_range(2, 0) == 0)
          setWr(w, $urandom_range(5, 0) == 0, $urandom_range(15, 0), {$urandom(), $urandom()});
      memEn = 2'($urandom_range(3, 0)); memPtrFile = 2'($urandom_range(3, 0));
      runBundle("R10 random", refCode());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule